// File: doc/BRIEF.md
# Variable-Block-Size Full-Search Motion Estimation Engine

This engine runs an exhaustive integer motion search for one 16×16 block of the current picture. It looks at every position of a square search window and finds the lowest sum of absolute differences (SAD) for each of 41 sub-block partitions. The current block is written into a register array row by row before the search, and it stays there for the whole run. The engine fetches reference pixels one 16-pixel column per cycle from an external memory that has a one-cycle read latency. Each column shifts into a 16×16 reference register array, so neighbouring candidates share fifteen of their sixteen columns.

One SAD tree evaluates one candidate per cycle. It first forms the sixteen 4×4 SADs and then adds them into every larger partition. Each partition has its own minimum tracker, so one pass over the window yields 41 independent best motion vectors. The 41 results are ready when the engine raises a one-cycle completion pulse, and they stay on the outputs until the next search starts.

Top module: `me_fs_engine`

## Requirements
- R1: A high `cur_we_i` at a clock edge writes `cur_data_i` into current-block row `cur_row_i`. Column j of that row comes from bits [8j+7:8j]. The stored block is used unchanged for every candidate of the following search.
- R2: A high `start_i` while `busy_o` is low starts a search and sets all 41 SAD outputs to 0xFFFF, visible in the next cycle. A `start_i` pulse while `busy_o` is high has no effect.
- R3: During a search the engine asserts `ref_rd_en_o` in 1504 consecutive cycles. For each window top row 0..31 in turn, it reads columns 0..46 in increasing order. `ref_col_data_i` must carry the requested column one cycle after the request, with window row top+i at bits [8i+7:8i].
- R4: The candidate whose top-left pixel sits at window column px and window row py (each 0..31) has motion vector (px−16, py−16). Each component is reported as 5-bit two's complement. All 1024 candidates are evaluated.
- R5: The partitions use output index k, with rectangles in 4×4-cell units on a 4×4 grid. k=0 is 16×16. k=1,2 are the top and bottom 16×8 halves. k=3,4 are the left and right 8×16 halves. k=5..8 are the 8×8 quadrants in raster order. k=9..16 are the 8×4 blocks, raster over 4 bands × 2 halves. k=17..24 are the 4×8 blocks, raster over 2 bands × 4 columns. k=25..40 are the 4×4 cells in raster order. Partition k uses bits [16k+15:16k] of `best_sad_o` and bits [5k+4:5k] of each MV output.
- R6: When the search completes, each partition reports the minimum SAD over all candidates and the motion vector of a candidate that achieves it.
- R7: When several candidates tie for a partition's minimum, the engine reports the one that comes first in raster scan order (py first, then px).
- R8: `done_o` is high for exactly one cycle, 1507 clock edges after the edge that accepted start. `busy_o` is high from the cycle after that edge up to, but not including, the `done_o` cycle.
- R9: Once the search completes, all SAD and MV outputs hold their values until the next accepted start.
- R10: A synchronous active-high reset clears `busy_o` and `done_o`, sets every SAD output to 0xFFFF and sets every MV output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a search (ignored while busy) |
| cur_we_i | input | 1 | Current-block row write enable |
| cur_row_i | input | 4 | Current-block row index |
| cur_data_i | input | 128 | Sixteen 8-bit pixels of one current row |
| ref_rd_en_o | output | 1 | Reference column read request |
| ref_rd_col_o | output | 6 | Requested window column (0..46) |
| ref_rd_top_o | output | 5 | Window row of the column's first pixel (0..31) |
| ref_col_data_i | input | 128 | Sixteen 8-bit reference pixels, one cycle after request |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| best_sad_o | output | 656 | 41 minimum SADs, 16 bits each |
| best_mvx_o | output | 205 | 41 horizontal MVs, 5-bit two's complement |
| best_mvy_o | output | 205 | 41 vertical MVs, 5-bit two's complement |

## Verification
The assertions assume that the reference source answers each read exactly one cycle later. They also assume that the current block is not rewritten while `busy_o` is high, since the engine neither buffers nor rejects such writes. The stimulus respects both conditions: its memory model registers the requested column on the request edge, and it loads the current block only between searches. It pulses start during a running search only to check that the pulse is ignored. The monotonic-minimum and hold properties rely on reset being held for at least one edge before the first start.

// File: rtl/me_fs_pkg.sv
package me_fs_pkg;
    localparam int PIX_W  = 8;
    localparam int BLK    = 16;
    localparam int SUB    = 4;
    localparam int GRID   = BLK / SUB;
    localparam int NSUB   = GRID * GRID;
    localparam int NPART  = 41;
    localparam int SR     = 32;
    localparam int WIN    = SR + BLK - 1;
    localparam int MV_W   = $clog2(SR);
    localparam int SAD4_W = 12;
    localparam int SAD_W  = 16;
    localparam int COL_W  = $clog2(WIN);
    localparam int TOP_W  = $clog2(SR);
    localparam int ROW_W  = $clog2(BLK);
    localparam int LINE_W = BLK * PIX_W;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} scan_st_e;

    typedef struct packed {
        logic            valid;
        logic            cand;
        logic            last;
        logic [MV_W-1:0] mvx;
        logic [MV_W-1:0] mvy;
    } tok_t;

    typedef struct packed {
        logic [2:0] r0;
        logic [2:0] c0;
        logic [2:0] h;
        logic [2:0] w;
    } rect_t;

    function automatic rect_t mk_rect(int r0, int c0, int h, int w);
        rect_t rc;
        rc.r0 = 3'(r0);
        rc.c0 = 3'(c0);
        rc.h  = 3'(h);
        rc.w  = 3'(w);
        return rc;
    endfunction

    function automatic rect_t part_rect(int k);
        int q;
        if (k == 0) begin
            return mk_rect(0, 0, 4, 4);
        end else if (k <= 2) begin
            return mk_rect((k - 1) * 2, 0, 2, 4);
        end else if (k <= 4) begin
            return mk_rect(0, (k - 3) * 2, 4, 2);
        end else if (k <= 8) begin
            q = k - 5;
            return mk_rect((q / 2) * 2, (q % 2) * 2, 2, 2);
        end else if (k <= 16) begin
            q = k - 9;
            return mk_rect(q / 2, (q % 2) * 2, 1, 2);
        end else if (k <= 24) begin
            q = k - 17;
            return mk_rect((q / 4) * 2, q % 4, 2, 1);
        end else begin
            q = k - 25;
            return mk_rect(q / 4, q % 4, 1, 1);
        end
    endfunction

    function automatic logic in_rect(rect_t rc, int r, int c);
        return (r >= int'(rc.r0)) && (r < int'(rc.r0) + int'(rc.h)) &&
               (c >= int'(rc.c0)) && (c < int'(rc.c0) + int'(rc.w));
    endfunction

    function automatic logic [PIX_W-1:0] absdiff(logic [PIX_W-1:0] a, logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction
endpackage

// File: rtl/me_cur_array.sv
module me_cur_array
    import me_fs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [LINE_W-1:0] data,
    output logic [PIX_W-1:0]  pix [BLK][BLK]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int y = 0; y < BLK; y++)
                for (int x = 0; x < BLK; x++)
                    pix[y][x] <= '0;
        end else if (we) begin
            for (int x = 0; x < BLK; x++)
                pix[row][x] <= data[x*PIX_W +: PIX_W];
        end
    end
endmodule

// File: rtl/me_ref_window.sv
module me_ref_window
    import me_fs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic [LINE_W-1:0] col_data,
    output logic [PIX_W-1:0]  pix [BLK][BLK]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int y = 0; y < BLK; y++)
                for (int x = 0; x < BLK; x++)
                    pix[y][x] <= '0;
        end else if (shift) begin
            for (int y = 0; y < BLK; y++) begin
                for (int x = 0; x < BLK - 1; x++)
                    pix[y][x] <= pix[y][x+1];
                pix[y][BLK-1] <= col_data[y*PIX_W +: PIX_W];
            end
        end
    end
endmodule

// File: rtl/me_sad4_stage.sv
module me_sad4_stage
    import me_fs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  cur [BLK][BLK],
    input  logic [PIX_W-1:0]  ref_px [BLK][BLK],
    output logic [SAD4_W-1:0] sad4 [NSUB]
);
    logic [SAD4_W-1:0] acc [NSUB];

    always_comb begin
        for (int s = 0; s < NSUB; s++) begin
            acc[s] = '0;
            for (int y = 0; y < SUB; y++)
                for (int x = 0; x < SUB; x++)
                    acc[s] = acc[s] + SAD4_W'(absdiff(
                        cur[(s / GRID) * SUB + y][(s % GRID) * SUB + x],
                        ref_px[(s / GRID) * SUB + y][(s % GRID) * SUB + x]));
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSUB; s++)
            sad4[s] <= rst ? '0 : acc[s];
    end
endmodule

// File: rtl/me_min_cmp.sv
module me_min_cmp
    import me_fs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  logic [SAD_W-1:0] sad_in,
    input  logic [MV_W-1:0]  mvx_in,
    input  logic [MV_W-1:0]  mvy_in,
    output logic [SAD_W-1:0] best_sad,
    output logic [MV_W-1:0]  best_mvx,
    output logic [MV_W-1:0]  best_mvy
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            best_sad <= '1;
            best_mvx <= '0;
            best_mvy <= '0;
        end else if (upd && (sad_in < best_sad)) begin
            best_sad <= sad_in;
            best_mvx <= mvx_in;
            best_mvy <= mvy_in;
        end
    end
endmodule

// File: rtl/me_part_bank.sv
module me_part_bank
    import me_fs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              upd,
    input  logic [MV_W-1:0]   mvx,
    input  logic [MV_W-1:0]   mvy,
    input  logic [SAD4_W-1:0] sad4 [NSUB],
    output logic [SAD_W-1:0]  best_sad [NPART],
    output logic [MV_W-1:0]   best_mvx [NPART],
    output logic [MV_W-1:0]   best_mvy [NPART]
);
    for (genvar k = 0; k < NPART; k++) begin : g_part
        localparam rect_t RC = part_rect(k);
        logic [SAD_W-1:0] psum;

        always_comb begin
            psum = '0;
            for (int s = 0; s < NSUB; s++)
                if (in_rect(RC, s / GRID, s % GRID))
                    psum = psum + SAD_W'(sad4[s]);
        end

        me_min_cmp u_cmp (
            .clk      (clk),
            .rst      (rst),
            .clr      (clr),
            .upd      (upd),
            .sad_in   (psum),
            .mvx_in   (mvx),
            .mvy_in   (mvy),
            .best_sad (best_sad[k]),
            .best_mvx (best_mvx[k]),
            .best_mvy (best_mvy[k])
        );
    end
endmodule

// File: rtl/me_scan_ctrl.sv
module me_scan_ctrl
    import me_fs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             rd_en,
    output logic [COL_W-1:0] rd_col,
    output logic [TOP_W-1:0] rd_top,
    output logic             shift_en,
    output logic             upd_en,
    output logic [MV_W-1:0]  upd_mvx,
    output logic [MV_W-1:0]  upd_mvy,
    output logic             clr,
    output logic             busy,
    output logic             done
);
    scan_st_e         state;
    logic [COL_W-1:0] col;
    logic [TOP_W-1:0] top;
    tok_t             iss, s1, s2, s3;
    logic             col_end, top_end;

    assign col_end = (col == COL_W'(WIN - 1));
    assign top_end = (top == TOP_W'(SR - 1));

    always_comb begin
        iss       = '0;
        iss.valid = (state == ST_RUN);
        iss.cand  = (col >= COL_W'(BLK - 1));
        iss.last  = col_end && top_end;
        iss.mvx   = MV_W'(int'(col) - (BLK - 1) - SR / 2);
        iss.mvy   = MV_W'(int'(top) - SR / 2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            col   <= '0;
            top   <= '0;
            s1    <= '0;
            s2    <= '0;
            s3    <= '0;
            done  <= 1'b0;
        end else begin
            s1   <= iss;
            s2   <= s1;
            s3   <= s2;
            done <= s3.valid && s3.last;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    col   <= '0;
                    top   <= '0;
                end
                ST_RUN: begin
                    if (col_end) begin
                        col <= '0;
                        if (top_end) state <= ST_DRAIN;
                        else         top   <= top + 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_DRAIN: if (s3.valid && s3.last) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_en    = (state == ST_RUN);
    assign rd_col   = col;
    assign rd_top   = top;
    assign shift_en = s1.valid;
    assign upd_en   = s3.valid && s3.cand;
    assign upd_mvx  = s3.mvx;
    assign upd_mvy  = s3.mvy;
    assign clr      = start && (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/me_fs_engine.sv
module me_fs_engine
    import me_fs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   cur_we_i,
    input  logic [ROW_W-1:0]       cur_row_i,
    input  logic [LINE_W-1:0]      cur_data_i,
    output logic                   ref_rd_en_o,
    output logic [COL_W-1:0]       ref_rd_col_o,
    output logic [TOP_W-1:0]       ref_rd_top_o,
    input  logic [LINE_W-1:0]      ref_col_data_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [NPART*SAD_W-1:0] best_sad_o,
    output logic [NPART*MV_W-1:0]  best_mvx_o,
    output logic [NPART*MV_W-1:0]  best_mvy_o
);
    logic [PIX_W-1:0]  cur_px [BLK][BLK];
    logic [PIX_W-1:0]  ref_px [BLK][BLK];
    logic [SAD4_W-1:0] sad4 [NSUB];
    logic [SAD_W-1:0]  bsad [NPART];
    logic [MV_W-1:0]   bmvx [NPART];
    logic [MV_W-1:0]   bmvy [NPART];
    logic              shift_en, upd_en, clr;
    logic [MV_W-1:0]   upd_mvx, upd_mvy;

    me_scan_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .rd_en    (ref_rd_en_o),
        .rd_col   (ref_rd_col_o),
        .rd_top   (ref_rd_top_o),
        .shift_en (shift_en),
        .upd_en   (upd_en),
        .upd_mvx  (upd_mvx),
        .upd_mvy  (upd_mvy),
        .clr      (clr),
        .busy     (busy_o),
        .done     (done_o)
    );

    me_cur_array u_cur (
        .clk  (clk),
        .rst  (rst),
        .we   (cur_we_i),
        .row  (cur_row_i),
        .data (cur_data_i),
        .pix  (cur_px)
    );

    me_ref_window u_ref (
        .clk      (clk),
        .rst      (rst),
        .shift    (shift_en),
        .col_data (ref_col_data_i),
        .pix      (ref_px)
    );

    me_sad4_stage u_sad4 (
        .clk    (clk),
        .rst    (rst),
        .cur    (cur_px),
        .ref_px (ref_px),
        .sad4   (sad4)
    );

    me_part_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .upd      (upd_en),
        .mvx      (upd_mvx),
        .mvy      (upd_mvy),
        .sad4     (sad4),
        .best_sad (bsad),
        .best_mvx (bmvx),
        .best_mvy (bmvy)
    );

    for (genvar k = 0; k < NPART; k++) begin : g_out
        assign best_sad_o[k*SAD_W +: SAD_W] = bsad[k];
        assign best_mvx_o[k*MV_W +: MV_W]   = bmvx[k];
        assign best_mvy_o[k*MV_W +: MV_W]   = bmvy[k];
    end
endmodule

// File: rtl/me_fs_engine_chk.sv
module me_fs_engine_chk
    import me_fs_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   start_i,
    input logic                   cur_we_i,
    input logic [ROW_W-1:0]       cur_row_i,
    input logic [LINE_W-1:0]      cur_data_i,
    input logic                   ref_rd_en_o,
    input logic [COL_W-1:0]       ref_rd_col_o,
    input logic [TOP_W-1:0]       ref_rd_top_o,
    input logic [LINE_W-1:0]      ref_col_data_i,
    input logic                   busy_o,
    input logic                   done_o,
    input logic [NPART*SAD_W-1:0] best_sad_o,
    input logic [NPART*MV_W-1:0]  best_mvx_o,
    input logic [NPART*MV_W-1:0]  best_mvy_o
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R3
    rd_range_chk: assert property (@(posedge clk) disable iff (rst)
        ref_rd_en_o |-> (busy_o && (ref_rd_col_o < COL_W'(WIN)) && (ref_rd_top_o <= TOP_W'(SR - 1))));

    // R3
    rd_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_rd_en_o && $past(ref_rd_en_o) && (ref_rd_col_o != '0)) |->
        ((ref_rd_col_o == $past(ref_rd_col_o) + 1'b1) && (ref_rd_top_o == $past(ref_rd_top_o))));

    // R2
    start_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (&best_sad_o));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(best_sad_o) && $stable(best_mvx_o) && $stable(best_mvy_o)));

    // R6
    min_mono_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (best_sad_o[SAD_W-1:0] <= $past(best_sad_o[SAD_W-1:0])));
endmodule

bind me_fs_engine me_fs_engine_chk chk_i (.*);

// File: tb/me_fs_engine_tb_top.sv
`timescale 1ns/1ps
module me_fs_engine_tb_top;
    localparam int NP   = 41;
    localparam int BS   = 16;
    localparam int SRCH = 32;
    localparam int WN   = SRCH + BS - 1;
    localparam int LAT  = SRCH * WN + 3;

    typedef struct {
        int sad [NP];
        int mvx [NP];
        int mvy [NP];
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         cur_we_i = 1'b0;
    logic [3:0]   cur_row_i = '0;
    logic [127:0] cur_data_i = '0;
    logic         ref_rd_en_o;
    logic [5:0]   ref_rd_col_o;
    logic [4:0]   ref_rd_top_o;
    logic [127:0] ref_col_data_i = '0;
    logic         busy_o, done_o;
    logic [NP*16-1:0] best_sad_o;
    logic [NP*5-1:0]  best_mvx_o, best_mvy_o;

    me_fs_engine dut_i (.*);

    always #10 clk = ~clk;

    logic [7:0] win_mem [WN][WN];
    logic [7:0] cur_mem [BS][BS];
    exp_t exp_q [$];
    int   n_chk = 0, n_err = 0, cyc = 0, st_cyc = 0, jobs_seen = 0;
    int   seq_err = 0, rd_cnt = 0, exp_col = 0, exp_top = 0;
    logic [NP*16-1:0] snap_sad;
    logic [NP*5-1:0]  snap_mvx, snap_mvy;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic get_rect(input int k, output int r0, output int c0, output int h, output int w);
        int q;
        if (k == 0)       begin r0 = 0; c0 = 0; h = 4; w = 4; end
        else if (k < 3)   begin r0 = 2 * (k - 1); c0 = 0; h = 2; w = 4; end
        else if (k < 5)   begin r0 = 0; c0 = 2 * (k - 3); h = 4; w = 2; end
        else if (k < 9)   begin q = k - 5;  r0 = 2 * (q / 2); c0 = 2 * (q % 2); h = 2; w = 2; end
        else if (k < 17)  begin q = k - 9;  r0 = q / 2; c0 = 2 * (q % 2); h = 1; w = 2; end
        else if (k < 25)  begin q = k - 17; r0 = 2 * (q / 4); c0 = q % 4; h = 2; w = 1; end
        else              begin q = k - 25; r0 = q / 4; c0 = q % 4; h = 1; w = 1; end
    endtask

    // Behavioural exhaustive search over the whole window (R4 R5 R6 R7)
    task automatic compute_exp(output exp_t e);
        int r0, c0, h, w, s, d;
        for (int k = 0; k < NP; k++) begin e.sad[k] = 1 << 30; e.mvx[k] = 0; e.mvy[k] = 0; end
        for (int py = 0; py < SRCH; py++) begin
            for (int px = 0; px < SRCH; px++) begin
                for (int k = 0; k < NP; k++) begin
                    get_rect(k, r0, c0, h, w);
                    s = 0;
                    for (int y = r0 * 4; y < (r0 + h) * 4; y++)
                        for (int x = c0 * 4; x < (c0 + w) * 4; x++) begin
                            d = int'(cur_mem[y][x]) - int'(win_mem[py + y][px + x]);
                            s += (d < 0) ? -d : d;
                        end
                    if (s < e.sad[k]) begin e.sad[k] = s; e.mvx[k] = px - 16; e.mvy[k] = py - 16; end
                end
            end
        end
    endtask

    // cycle counter
    initial forever begin @(posedge clk); cyc++; end

    // reference memory model: one-cycle read latency, request order check (R3)
    initial forever begin
        logic [127:0] v;
        @(posedge clk);
        if (ref_rd_en_o) begin
            for (int i = 0; i < BS; i++) v[i*8 +: 8] = win_mem[int'(ref_rd_top_o) + i][int'(ref_rd_col_o)];
            ref_col_data_i <= v;
            if (int'(ref_rd_col_o) != exp_col || int'(ref_rd_top_o) != exp_top) seq_err++;
            rd_cnt++;
            if (exp_col == WN - 1) begin exp_col = 0; exp_top++; end else exp_col++;
        end
    end

    // monitor / scoreboard
    initial forever begin
        exp_t e;
        @(negedge clk);
        if (done_o) begin
            chk(exp_q.size() > 0, "R6", "result without expectation", 0, 1);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(cyc - st_cyc - 1 == LAT, "R8", "done latency", cyc - st_cyc - 1, LAT);
                chk(seq_err == 0 && rd_cnt == SRCH * WN, "R3", "read sequence count", rd_cnt - seq_err, SRCH * WN);
                for (int k = 0; k < NP; k++) begin
                    chk(int'(best_sad_o[k*16 +: 16]) == e.sad[k], "R6", $sformatf("sad part %0d (R1 R5)", k),
                        int'(best_sad_o[k*16 +: 16]), e.sad[k]);
                    chk(best_mvx_o[k*5 +: 5] == 5'(e.mvx[k]) && best_mvy_o[k*5 +: 5] == 5'(e.mvy[k]), "R4",
                        $sformatf("mv part %0d x/y packed (R7)", k),
                        int'({best_mvx_o[k*5 +: 5], best_mvy_o[k*5 +: 5]}), int'({5'(e.mvx[k]), 5'(e.mvy[k])}));
                end
            end
            snap_sad = best_sad_o; snap_mvx = best_mvx_o; snap_mvy = best_mvy_o;
            jobs_seen++;
        end
    end

    // watchdog
    initial begin
        repeat (40000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    task automatic load_cur();
        for (int y = 0; y < BS; y++) begin
            @(negedge clk);
            cur_we_i = 1'b1; cur_row_i = 4'(y);
            for (int x = 0; x < BS; x++) cur_data_i[x*8 +: 8] = cur_mem[y][x];
        end
        @(negedge clk);
        cur_we_i = 1'b0;
    endtask

    task automatic run_job(input int n, input bit poke_start);
        exp_t e;
        load_cur();
        compute_exp(e);
        exp_q.push_back(e);
        seq_err = 0; rd_cnt = 0; exp_col = 0; exp_top = 0;
        @(negedge clk);
        start_i = 1'b1; st_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
        chk(&best_sad_o, "R2", "minima cleared after start", int'(best_sad_o[15:0]), 65535);
        chk(busy_o == 1'b1, "R8", "busy after start", int'(busy_o), 1);
        if (poke_start) begin
            repeat (600) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (jobs_seen == n);
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done one cycle", int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(busy_o == 1'b0 && done_o == 1'b0, "R10", "busy/done after reset", int'({busy_o, done_o}), 0);
        chk(&best_sad_o, "R10", "sad after reset", int'(best_sad_o[15:0]), 65535);
        chk(best_mvx_o == '0 && best_mvy_o == '0, "R10", "mv after reset", int'(best_mvx_o[4:0]), 0);
        chk(ref_rd_en_o == 1'b0, "R3", "no read while idle", int'(ref_rd_en_o), 0);

        // job 1: random data
        for (int y = 0; y < WN; y++) for (int x = 0; x < WN; x++) win_mem[y][x] = 8'($urandom);
        for (int y = 0; y < BS; y++) for (int x = 0; x < BS; x++) cur_mem[y][x] = 8'($urandom);
        run_job(1, 1'b0);

        // job 2: flat data, every candidate ties (R7)
        for (int y = 0; y < WN; y++) for (int x = 0; x < WN; x++) win_mem[y][x] = 8'd30;
        for (int y = 0; y < BS; y++) for (int x = 0; x < BS; x++) cur_mem[y][x] = 8'd100;
        run_job(2, 1'b0);
        chk(best_mvx_o[4:0] == 5'h10 && best_mvy_o[4:0] == 5'h10, "R7", "tie keeps first 16x16",
            int'({best_mvx_o[4:0], best_mvy_o[4:0]}), int'({5'h10, 5'h10}));
        chk(best_mvx_o[40*5 +: 5] == 5'h10 && best_sad_o[40*16 +: 16] == 16'd1120, "R7", "tie keeps first 4x4",
            int'(best_sad_o[40*16 +: 16]), 1120);

        // job 3: current block embedded at window (20,5)
        for (int y = 0; y < WN; y++) for (int x = 0; x < WN; x++) win_mem[y][x] = 8'($urandom);
        for (int y = 0; y < BS; y++) for (int x = 0; x < BS; x++) cur_mem[y][x] = win_mem[5 + y][20 + x];
        run_job(3, 1'b0);
        chk(best_sad_o[15:0] == 16'd0 && best_mvx_o[4:0] == 5'd4 && best_mvy_o[4:0] == 5'd21, "R4",
            "exact match mv (4,-11)", int'({best_mvx_o[4:0], best_mvy_o[4:0]}), int'({5'd4, 5'd21}));

        // job 4: random, start pulse while busy must be ignored (R2), then hold (R9)
        for (int y = 0; y < WN; y++) for (int x = 0; x < WN; x++) win_mem[y][x] = 8'($urandom);
        for (int y = 0; y < BS; y++) for (int x = 0; x < BS; x++) cur_mem[y][x] = 8'($urandom);
        run_job(4, 1'b1);
        chk(exp_q.size() == 0, "R2", "no extra search from busy start", exp_q.size(), 0);
        repeat (25) @(negedge clk);
        chk(best_sad_o == snap_sad && best_mvx_o == snap_mvx && best_mvy_o == snap_mvy, "R9",
            "results held after done", int'(best_sad_o[15:0]), int'(snap_sad[15:0]));
        chk(busy_o == 1'b0 && done_o == 1'b0, "R2", "idle after ignored start", int'({busy_o, done_o}), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule